// File: doc/BRIEF.md
# Three-Field Sparse-Prime Reducer

This block reduces a double-width integer modulo one of three fixed sparse primes of 192, 224 and 256 bits. A 2-bit field code picks the prime, and the code travels with each operand down the pipeline. The primes are 2^192 − 2^64 − 1, 2^224 − 2^96 + 1 and 2^256 − 2^224 + 2^192 + 2^96 − 1. The block sits behind a wide multiplier and turns its raw product into a canonical field element.

Each prime has a special form, so no division or generic reduction is needed. The input is cut into 32-bit words. For the selected prime, a fixed rewiring of those words builds an additive sum U and a subtractive sum V. The result is U − V, which lies within a few multiples of p of zero.

A final stage tries every small multiple of p in parallel. It keeps the single candidate that lands in [0, p). The block takes one operand every cycle and returns each result exactly three cycles later. Valid travels alongside the data, and there is no back-pressure.

Top module: `sparse_prime_reducer`

## Requirements
- R1: With field code 0, the result equals the low 384 bits of the input modulo 2^192 − 2^64 − 1.
- R2: With field code 1, the result equals the low 448 bits of the input modulo 2^224 − 2^96 + 1.
- R3: With field code 2, the result equals the full 512-bit input modulo 2^256 − 2^224 + 2^192 + 2^96 − 1.
- R4: For every input value, including ones at or above p squared such as all-ones, the result lies in [0, p).
- R5: For codes 0 and 1, input bits at and above bit 2n (n = prime width) have no effect on the result.
- R6: Field code 3 is reserved. It yields a result of zero with the error flag high. Every other code yields the error flag low.
- R7: The output valid is high exactly three cycles after the input valid. The error flag and result belong to the operand accepted three cycles earlier. Idle input cycles produce idle output cycles.
- R8: A new operand is accepted every cycle, with any mix of field codes back to back.
- R9: While reset is high, the output valid, error flag and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand valid |
| in_fld | input | 2 | Field code: 0 = 192-bit, 1 = 224-bit, 2 = 256-bit, 3 = reserved |
| in_prod | input | 512 | Double-width value to reduce |
| out_vld | output | 1 | Result valid, three cycles after in_vld |
| out_err | output | 1 | Reserved field code was used |
| out_res | output | 256 | Reduced value, zero-extended above the prime width |

## Verification
The three stages can hold operands of different primes at the same time. The correction stage may therefore pick among candidates built from one prime's multiples while the fold stage rewires words for another prime. The bench provokes this with long back-to-back streams whose field code changes at random every cycle. It also injects a reserved code between two valid codes. Each output is compared against an independent behavioural remainder of the masked input. A reserved code must not disturb its neighbours' results or error flags.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int WORD_W  = 32;
  localparam int PROD_W  = 512;
  localparam int FIELD_W = 256;
  localparam int ACC_W   = FIELD_W + 8;
  localparam int NWORDS  = PROD_W / WORD_W;
  localparam int K_LO    = -8;
  localparam int K_HI    = 5;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    FLD_192 = 2'd0,
    FLD_224 = 2'd1,
    FLD_256 = 2'd2,
    FLD_RSV = 2'd3
  } fld_e;

  typedef struct packed {
    acc_t pos;
    acc_t neg;
  } split_t;

  localparam logic [FIELD_W-1:0] PR192 =
    (256'd1 << 192) - (256'd1 << 64) - 256'd1;
  localparam logic [FIELD_W-1:0] PR224 =
    (256'd1 << 224) - (256'd1 << 96) + 256'd1;
  localparam logic [FIELD_W-1:0] PR256 =
    ~256'd0 - (256'd1 << 224) + (256'd1 << 192) + (256'd1 << 96);

  localparam word_t ZW = '0;

  function automatic acc_t field_prime(input fld_e f);
    case (f)
      FLD_192: return acc_t'(PR192);
      FLD_224: return acc_t'(PR224);
      default: return acc_t'(PR256);
    endcase
  endfunction

  function automatic word_t wd(input logic [PROD_W-1:0] x, input int i);
    return x[i*WORD_W +: WORD_W];
  endfunction

  // 192-bit field: only additive terms
  function automatic split_t fold_192(input logic [PROD_W-1:0] x);
    word_t a [NWORDS];
    split_t r;
    for (int i = 0; i < NWORDS; i++) a[i] = wd(x, i);
    r.pos = acc_t'({a[5], a[4], a[3], a[2], a[1], a[0]})
          + acc_t'({ZW, ZW, a[7], a[6], a[7], a[6]})
          + acc_t'({a[9], a[8], a[9], a[8], ZW, ZW})
          + acc_t'({a[11], a[10], a[11], a[10], a[11], a[10]});
    r.neg = '0;
    return r;
  endfunction

  function automatic split_t fold_224(input logic [PROD_W-1:0] x);
    word_t a [NWORDS];
    split_t r;
    for (int i = 0; i < NWORDS; i++) a[i] = wd(x, i);
    r.pos = acc_t'({a[6], a[5], a[4], a[3], a[2], a[1], a[0]})
          + acc_t'({a[10], a[9], a[8], a[7], ZW, ZW, ZW})
          + acc_t'({ZW, a[13], a[12], a[11], ZW, ZW, ZW});
    r.neg = acc_t'({a[13], a[12], a[11], a[10], a[9], a[8], a[7]})
          + acc_t'({ZW, ZW, ZW, ZW, a[13], a[12], a[11]});
    return r;
  endfunction

  function automatic split_t fold_256(input logic [PROD_W-1:0] x);
    word_t a [NWORDS];
    split_t r;
    for (int i = 0; i < NWORDS; i++) a[i] = wd(x, i);
    r.pos = acc_t'({a[7], a[6], a[5], a[4], a[3], a[2], a[1], a[0]})
          + (acc_t'({a[15], a[14], a[13], a[12], a[11], ZW, ZW, ZW}) << 1)
          + (acc_t'({ZW, a[15], a[14], a[13], a[12], ZW, ZW, ZW}) << 1)
          + acc_t'({a[15], a[14], ZW, ZW, ZW, a[10], a[9], a[8]})
          + acc_t'({a[8], a[13], a[15], a[14], a[13], a[11], a[10], a[9]});
    r.neg = acc_t'({a[10], a[8], ZW, ZW, ZW, a[13], a[12], a[11]})
          + acc_t'({a[11], a[9], ZW, ZW, a[15], a[14], a[13], a[12]})
          + acc_t'({a[12], ZW, a[10], a[9], a[8], a[15], a[14], a[13]})
          + acc_t'({a[13], ZW, a[11], a[10], a[9], ZW, a[15], a[14]});
    return r;
  endfunction
endpackage

// File: rtl/spr_fold.sv
module spr_fold
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  fld_e              fld_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              vld_o,
  output fld_e              fld_o,
  output acc_t              pos_o,
  output acc_t              neg_o
);
  split_t nx;

  always_comb begin
    case (fld_i)
      FLD_192: nx = fold_192(prod_i);
      FLD_224: nx = fold_224(prod_i);
      FLD_256: nx = fold_256(prod_i);
      default: nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      fld_o <= FLD_192;
      pos_o <= '0;
      neg_o <= '0;
    end else begin
      vld_o <= vld_i;
      fld_o <= fld_i;
      pos_o <= nx.pos;
      neg_o <= nx.neg;
    end
  end
endmodule

// File: rtl/spr_diff.sv
module spr_diff
  import spr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  fld_e fld_i,
  input  acc_t pos_i,
  input  acc_t neg_i,
  output logic vld_o,
  output fld_e fld_o,
  output acc_t diff_o
);
  localparam int GUARD = ACC_W - FIELD_W - 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      fld_o  <= FLD_192;
      diff_o <= '0;
    end else begin
      vld_o  <= vld_i;
      fld_o  <= fld_i;
      diff_o <= pos_i - neg_i;
    end
  end

  // signed difference must stay inside +/- 2^(FIELD_W+3)
  assert_diff_bound_R4: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ((diff_o[ACC_W-1 -: GUARD] == '0) || (diff_o[ACC_W-1 -: GUARD] == '1)));
endmodule

// File: rtl/spr_fix.sv
module spr_fix
  import spr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_i,
  input  fld_e               fld_i,
  input  acc_t               diff_i,
  output logic               vld_o,
  output logic               err_o,
  output logic [FIELD_W-1:0] res_o
);
  localparam int NK = K_HI - K_LO + 1;

  acc_t               pmod;
  acc_t               cand [NK];
  logic [NK-1:0]      hit;
  logic [FIELD_W-1:0] pick;
  fld_e               fld_q;

  assign pmod = field_prime(fld_i);

  for (genvar j = 0; j < NK; j++) begin : g_k
    localparam int K   = K_LO + j;
    localparam int MAG = (K < 0) ? -K : K;
    if (K < 0) begin : g_sub
      assign cand[j] = diff_i - acc_t'(MAG) * pmod;
    end else begin : g_add
      assign cand[j] = diff_i + acc_t'(MAG) * pmod;
    end
    assign hit[j] = ~cand[j][ACC_W-1] && (cand[j] < pmod);
  end

  always_comb begin
    pick = '0;
    for (int j = 0; j < NK; j++) begin
      if (hit[j]) pick = pick | cand[j][FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      err_o <= 1'b0;
      res_o <= '0;
      fld_q <= FLD_192;
    end else begin
      vld_o <= vld_i;
      err_o <= (fld_i == FLD_RSV);
      res_o <= (fld_i == FLD_RSV) ? '0 : pick;
      fld_q <= fld_i;
    end
  end

  assert_one_fit_R4: assert property (@(posedge clk) disable iff (rst)
    (vld_i && fld_i != FLD_RSV) |-> ($countones(hit) == 1));

  assert_res_below_p_R4: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !err_o) |-> (acc_t'(res_o) < field_prime(fld_q)));
endmodule

// File: rtl/sparse_prime_reducer.sv
module sparse_prime_reducer
  import spr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [1:0]         in_fld,
  input  logic [PROD_W-1:0]  in_prod,
  output logic               out_vld,
  output logic               out_err,
  output logic [FIELD_W-1:0] out_res
);
  logic s1_vld, s2_vld;
  fld_e s1_fld, s2_fld;
  acc_t s1_pos, s1_neg, s2_diff;

  spr_fold u_fold (
    .clk(clk), .rst(rst), .vld_i(in_vld), .fld_i(fld_e'(in_fld)), .prod_i(in_prod),
    .vld_o(s1_vld), .fld_o(s1_fld), .pos_o(s1_pos), .neg_o(s1_neg)
  );

  spr_diff u_diff (
    .clk(clk), .rst(rst), .vld_i(s1_vld), .fld_i(s1_fld), .pos_i(s1_pos), .neg_i(s1_neg),
    .vld_o(s2_vld), .fld_o(s2_fld), .diff_o(s2_diff)
  );

  spr_fix u_fix (
    .clk(clk), .rst(rst), .vld_i(s2_vld), .fld_i(s2_fld), .diff_i(s2_diff),
    .vld_o(out_vld), .err_o(out_err), .res_o(out_res)
  );

  // cycles since reset release, saturating, to bound $past depth
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_lat_R7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  assert_err_track_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_vld) |-> (out_err == ($past(in_fld, 3) == 2'd3)));

  assert_rsv_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_err) |-> (out_res == '0));
endmodule

// File: tb/test_sparse_prime_reducer.sv
`timescale 1ns/1ps
module test_sparse_prime_reducer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [1:0]   in_fld = 2'd0;
  logic [511:0] in_prod = '0;
  logic         out_vld;
  logic         out_err;
  logic [255:0] out_res;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sparse_prime_reducer i_sparse_prime_reducer (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_fld(in_fld), .in_prod(in_prod),
    .out_vld(out_vld), .out_err(out_err), .out_res(out_res)
  );

  function automatic logic [511:0] prime_of(input int f);
    case (f)
      0: return (512'd1 << 192) - (512'd1 << 64) - 512'd1;
      1: return (512'd1 << 224) - (512'd1 << 96) + 512'd1;
      default: return (512'd1 << 256) - (512'd1 << 224) + (512'd1 << 192)
                      + (512'd1 << 96) - 512'd1;
    endcase
  endfunction

  function automatic int width_of(input int f);
    return (f == 0) ? 192 : (f == 1) ? 224 : 256;
  endfunction

  function automatic logic [511:0] low_mask(input int f);
    return (512'd1 << (2 * width_of(f))) - 512'd1;
  endfunction

  function automatic logic [255:0] ref_red(input int f, input logic [511:0] x);
    logic [511:0] r;
    r = (x & low_mask(f)) % prime_of(f);
    return r[255:0];
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] rnd_below(input int f);
    return {256'd0, rnd512() >> 256} % prime_of(f);
  endfunction

  function automatic string tag_of(input int f);
    return (f == 0) ? "R1" : (f == 1) ? "R2" : "R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expectation slots: index 0 = newest operand
  logic         e_vld [3];
  logic         e_err [3];
  logic [255:0] e_res [3];
  string        e_tag [3];

  task automatic cyc(input logic v, input logic [1:0] f, input logic [511:0] x,
                     input string tag);
    @(negedge clk);
    chk(out_vld == e_vld[2], {e_tag[2], " valid"}, 256'(out_vld), 256'(e_vld[2]));
    if (e_vld[2]) begin
      chk(out_err == e_err[2], {e_tag[2], " err"}, 256'(out_err), 256'(e_err[2]));
      chk(out_res == e_res[2], {e_tag[2], " result"}, out_res, e_res[2]);
    end
    for (int i = 2; i > 0; i--) begin
      e_vld[i] = e_vld[i-1];
      e_err[i] = e_err[i-1];
      e_res[i] = e_res[i-1];
      e_tag[i] = e_tag[i-1];
    end
    in_vld  = v;
    in_fld  = f;
    in_prod = x;
    e_vld[0] = v;
    e_err[0] = (f == 2'd3);
    e_res[0] = (f == 2'd3) ? '0 : ref_red(int'(f), x);
    e_tag[0] = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] pv, edge_v [4], a, b;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin
      e_vld[i] = 1'b0; e_err[i] = 1'b0; e_res[i] = '0; e_tag[i] = "R9";
    end
    // R9: reset state, inputs active during reset
    @(negedge clk);
    in_vld = 1'b1; in_fld = 2'd3; in_prod = rnd512();
    repeat (4) @(negedge clk);
    chk(out_vld == 1'b0, "R9 valid", 256'(out_vld), 256'd0);
    chk(out_err == 1'b0, "R9 err", 256'(out_err), 256'd0);
    chk(out_res == '0, "R9 result", out_res, 256'd0);
    in_vld = 1'b0; in_fld = 2'd0; in_prod = '0;
    rst = 1'b0;

    // R1 R2 R3: edge operand pairs
    for (int f = 0; f < 3; f++) begin
      pv = prime_of(f);
      edge_v[0] = 512'd0; edge_v[1] = 512'd1;
      edge_v[2] = pv - 512'd1; edge_v[3] = pv - 512'd2;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          cyc(1'b1, 2'(f), edge_v[i] * edge_v[j], tag_of(f));
    end

    // R4: values far above p squared
    for (int f = 0; f < 3; f++) begin
      cyc(1'b1, 2'(f), low_mask(f), "R4");
      cyc(1'b1, 2'(f), low_mask(f) - prime_of(f), "R4");
      cyc(1'b1, 2'(f), low_mask(f) & rnd512(), "R4");
    end

    // R5: garbage above 2n bits must not matter
    for (int k = 0; k < 6; k++) begin
      int f = k % 2;
      a = rnd_below(f); b = rnd_below(f);
      cyc(1'b1, 2'(f), (a * b) | (rnd512() & ~low_mask(f)), "R5");
      cyc(1'b1, 2'(f), ~low_mask(f), "R5");
    end

    // R6: reserved code between valid codes
    cyc(1'b1, 2'd0, rnd_below(0) * rnd_below(0), "R6");
    cyc(1'b1, 2'd3, rnd512(), "R6");
    cyc(1'b1, 2'd2, rnd_below(2) * rnd_below(2), "R6");
    cyc(1'b1, 2'd3, '1, "R6");
    cyc(1'b1, 2'd1, rnd_below(1) * rnd_below(1), "R6");

    // R7: idle gaps and isolated operands
    cyc(1'b0, 2'd3, rnd512(), "R7");
    cyc(1'b1, 2'd2, rnd_below(2) * rnd_below(2), "R7");
    cyc(1'b0, 2'd0, rnd512(), "R7");
    cyc(1'b0, 2'd1, rnd512(), "R7");
    cyc(1'b1, 2'd1, rnd_below(1) * rnd_below(1), "R7");
    cyc(1'b0, 2'd2, '1, "R7");

    // R8: back-to-back mixed fields
    for (int k = 0; k < 400; k++) begin
      int f = int'($urandom % 3);
      a = rnd_below(f); b = rnd_below(f);
      cyc(1'b1, 2'(f), a * b, "R8");
    end

    repeat (4) cyc(1'b0, 2'd0, '0, "R7");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule